// File: doc/BRIEF.md
# Dual watchdog reset supervisor

This block supervises a processor-based system. It owns the active-low system reset and the gating of two regulator enables. Reset is forced by any of these: power-on, a manual push-button input, a monitored supply rail reported low by an external comparator, or one of two watchdog timers. The processor keeps each watchdog alive by toggling its refresh input. Either edge direction counts as a refresh.

The two watchdogs have different effects. The first only resets the processor. The second also removes power: both regulator enables drop for a fixed off period. They then return in a fixed order, the linear regulator first and the buck a set number of cycles later. An undervoltage lockout input gates both enables off while it is active. A registered cause code records why the most recent reset happened, so software can read it after it restarts. The code returns to "none" once a quiet period has passed after reset release.

All comparator results arrive as synchronous digital inputs. Every timeout is a clock-cycle count set by a parameter.

Top module: `wdog_supervisor`

## Requirements
- R1: A change of level on `wd1_kick`, rising or falling, clears the first watchdog's count. Repeated toggling with gaps shorter than `WD1_CYC` cycles never causes a reset.
- R2: Suppose the first watchdog is enabled and `wd1_kick` was last seen changing at clock edge k0. Then `sys_rst_n` goes low after edge k0+`WD1_CYC` and stays high through edge k0+`WD1_CYC`-1. `reset_cause` becomes 2'b01, and the regulator enables are not affected.
- R3: The first watchdog is disabled while `wd1_float`=1 and `wd1_mode`=0. With `wd1_mode`=1 it stays enabled even when floating. When it becomes enabled at edge k0, it expires at edge k0+`WD1_CYC`-1.
- R4: `mreset_n` or `rail_ok` sampled low at a clock edge drives `sys_rst_n` low after that edge. If reset was not already asserted, `reset_cause` becomes 2'b11.
- R5: Suppose the last edge sampling `mreset_n`/`rail_ok` low is followed by clean edge k. Then `sys_rst_n` stays low through edge k+`RST_HOLD`-2 and goes high after edge k+`RST_HOLD`-1.
- R6: A low on `rail_ok` behaves as R4 and R5 describe, with the release timed from the edge at which the rail is first seen recovered.
- R7: Suppose the second watchdog expires at edge e, which is `WD2_CYC` edges after its last refresh. Then reset asserts after e and `reset_cause` becomes 2'b10. Both enables are low from edge e+1. `ldo_en` returns after edge e+`POFF_CYC`+1 and `buck_en` after edge e+`POFF_CYC`+`LDO_LEAD`+1. Reset releases after edge e+`POFF_CYC`+`LDO_LEAD`+`RST_HOLD`.
- R8: Each enable output is registered, one cycle after its inputs: `ldo_en_req` (or `buck_en_req`) AND the internal power-cycle gate AND NOT `uv_lock`.
- R9: `reset_cause` encodes 00 none, 01 first watchdog, 10 second watchdog, 11 manual or rail. It is 00 after power-on. A manual or rail event during an already asserted reset leaves it unchanged.
- R10: After reset releases at edge r with a nonzero cause, `reset_cause` clears to 00 after edge r+`STAT_CLR`, unless a new reset intervenes.
- R11: Both watchdog counts are held at zero while reset is asserted. A watchdog first counts from the edge after reset release.
- R12: While `rst_n` is low, `sys_rst_n`, `ldo_en` and `buck_en` are low. After `rst_n` rises, reset is held until edge `RST_HOLD`-1 after the first clean edge, as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| wd1_kick | input | 1 | Refresh input of the first watchdog (either edge) |
| wd1_float | input | 1 | High when the first refresh input is undriven |
| wd1_mode | input | 1 | Keeps the first watchdog enabled while floating |
| wd2_kick | input | 1 | Refresh input of the second watchdog (either edge) |
| mreset_n | input | 1 | Manual reset request, active low |
| rail_ok | input | 1 | Monitored rail comparator, low = rail under threshold |
| uv_lock | input | 1 | Undervoltage lockout, high forces enables off |
| ldo_en_req | input | 1 | External enable request for the linear regulator |
| buck_en_req | input | 1 | External enable request for the buck regulator |
| sys_rst_n | output | 1 | System reset, active low |
| ldo_en | output | 1 | Linear regulator enable |
| buck_en | output | 1 | Buck regulator enable |
| reset_cause | output | 2 | Cause of the latest reset (00/01/10/11) |

## Verification
On every cycle the assertions check these local properties: watchdog counts stay cleared while reset or disable holds them, and a disabled watchdog never expires. They also check that a manual or rail low is followed by reset, and that a second-watchdog expiry leaves cause 10 with reset asserted. Finally they check that the buck gate never leads the linear gate and that lockout removes both enables. Exact timings are shown only by the bench's scenarios: the timeout lengths, the release delay after each source clears, the ordered power-up after a second-watchdog event, and the status clear period. The same holds for the proof that a reset restarts the watchdog count rather than pausing it.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_WD1  = 2'b01,
        CAUSE_WD2  = 2'b10,
        CAUSE_EXT  = 2'b11
    } cause_e;

    typedef enum logic [1:0] {
        PS_IDLE = 2'b00,
        PS_OFF  = 2'b01,
        PS_LDO  = 2'b10
    } pwr_state_e;

endpackage

// File: rtl/sup_wdog.sv
module sup_wdog #(
    parameter int LIMIT = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    input  logic enable,
    input  logic hold,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    typedef struct packed {
        logic          kick;
        logic [CW-1:0] cnt;
    } wd_st_t;

    wd_st_t st_d, st_q;
    logic   edge_seen;

    always_comb begin
        st_d      = st_q;
        st_d.kick = kick;
        edge_seen = kick ^ st_q.kick;
        expire    = enable && !hold && !edge_seen && (st_q.cnt == LAST);
        if (hold || !enable || edge_seen || expire) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (st_q.cnt == '0)); // R11
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !expire); // R3
    AST_KICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (kick != st_q.kick) |=> (st_q.cnt == '0)); // R1

endmodule

// File: rtl/sup_rstseq.sv
module sup_rstseq
    import sup_pkg::*;
#(
    parameter int RST_HOLD = 12,
    parameter int STAT_CLR = 80
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   mreset_n,
    input  logic   rail_ok,
    input  logic   pcycle_busy,
    input  logic   wd1_exp,
    input  logic   wd2_exp,
    output logic   rst_act,
    output cause_e cause
);
    localparam int HW = $clog2(RST_HOLD + 1);
    localparam int SW = $clog2(STAT_CLR + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(RST_HOLD - 1);
    localparam logic [SW-1:0] STAT_LAST = SW'(STAT_CLR - 1);

    typedef struct packed {
        logic          act;
        logic [HW-1:0] hcnt;
        logic [SW-1:0] scnt;
        cause_e        cause;
    } rs_st_t;

    rs_st_t st_d, st_q;
    logic   ext_req;
    logic   trig;

    always_comb begin
        st_d    = st_q;
        ext_req = !mreset_n || !rail_ok;
        trig    = ext_req || pcycle_busy || wd1_exp || wd2_exp;

        if (trig) begin
            st_d.act  = 1'b1;
            st_d.hcnt = '0;
        end else if (st_q.act) begin
            if (st_q.hcnt == HOLD_LAST) begin
                st_d.act  = 1'b0;
                st_d.hcnt = '0;
            end else begin
                st_d.hcnt = st_q.hcnt + 1'b1;
            end
        end

        if (st_q.act || st_q.cause == CAUSE_NONE) begin
            st_d.scnt = '0;
        end else if (st_q.scnt == STAT_LAST) begin
            st_d.scnt  = '0;
            st_d.cause = CAUSE_NONE;
        end else begin
            st_d.scnt = st_q.scnt + 1'b1;
        end

        if (wd2_exp) begin
            st_d.cause = CAUSE_WD2;
        end else if (wd1_exp) begin
            st_d.cause = CAUSE_WD1;
        end else if (ext_req && !st_q.act) begin
            st_d.cause = CAUSE_EXT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.act   <= 1'b1;
            st_q.hcnt  <= '0;
            st_q.scnt  <= '0;
            st_q.cause <= CAUSE_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_act = st_q.act;
    assign cause   = st_q.cause;

    AST_EXT_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreset_n || !rail_ok) |=> rst_act); // R4
    AST_WD2_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wd2_exp |=> (rst_act && cause == CAUSE_WD2)); // R7
    AST_CAUSE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_act && !wd1_exp && !wd2_exp) |=> $stable(cause)); // R9

endmodule

// File: rtl/sup_pwrseq.sv
module sup_pwrseq
    import sup_pkg::*;
#(
    parameter int POFF_CYC = 30,
    parameter int LDO_LEAD = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wd2_exp,
    output logic ldo_gate,
    output logic buck_gate,
    output logic busy
);
    localparam int MAXC = (POFF_CYC > LDO_LEAD) ? POFF_CYC : LDO_LEAD;
    localparam int PW   = $clog2(MAXC + 1);
    localparam logic [PW-1:0] OFF_LAST  = PW'(POFF_CYC - 1);
    localparam logic [PW-1:0] LEAD_LAST = PW'(LDO_LEAD - 1);

    typedef struct packed {
        pwr_state_e    st;
        logic [PW-1:0] cnt;
    } ps_st_t;

    ps_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.st)
            PS_IDLE: begin
                if (wd2_exp) begin
                    st_d.st  = PS_OFF;
                    st_d.cnt = '0;
                end
            end
            PS_OFF: begin
                if (st_q.cnt == OFF_LAST) begin
                    st_d.st  = PS_LDO;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PS_LDO: begin
                if (st_q.cnt == LEAD_LAST) begin
                    st_d.st  = PS_IDLE;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: begin
                st_d.st  = PS_IDLE;
                st_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st  <= PS_IDLE;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ldo_gate  = (st_q.st != PS_OFF);
    assign buck_gate = (st_q.st == PS_IDLE);
    assign busy      = (st_q.st != PS_IDLE);

    AST_BUCK_NOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        buck_gate |-> ldo_gate); // R7
    AST_LDO_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ldo_gate) |-> !buck_gate); // R7
    AST_EXPIRY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wd2_exp && !busy) |=> (!ldo_gate && !buck_gate)); // R7

endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
    import sup_pkg::*;
#(
    parameter int WD1_CYC  = 60,
    parameter int WD2_CYC  = 150,
    parameter int RST_HOLD = 12,
    parameter int POFF_CYC = 30,
    parameter int LDO_LEAD = 5,
    parameter int STAT_CLR = 80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wd1_kick,
    input  logic       wd1_float,
    input  logic       wd1_mode,
    input  logic       wd2_kick,
    input  logic       mreset_n,
    input  logic       rail_ok,
    input  logic       uv_lock,
    input  logic       ldo_en_req,
    input  logic       buck_en_req,
    output logic       sys_rst_n,
    output logic       ldo_en,
    output logic       buck_en,
    output logic [1:0] reset_cause
);
    typedef struct packed {
        logic ldo;
        logic buck;
    } en_st_t;

    en_st_t en_d, en_q;
    logic   rst_act;
    logic   wd1_en;
    logic   wd1_exp;
    logic   wd2_exp;
    logic   ldo_gate;
    logic   buck_gate;
    logic   pc_busy;
    cause_e cause;

    assign wd1_en = !(wd1_float && !wd1_mode);

    sup_wdog #(.LIMIT(WD1_CYC)) u_wd1 (
        .clk    (clk),
        .rst_n  (rst_n),
        .kick   (wd1_kick),
        .enable (wd1_en),
        .hold   (rst_act),
        .expire (wd1_exp)
    );

    sup_wdog #(.LIMIT(WD2_CYC)) u_wd2 (
        .clk    (clk),
        .rst_n  (rst_n),
        .kick   (wd2_kick),
        .enable (1'b1),
        .hold   (rst_act),
        .expire (wd2_exp)
    );

    sup_pwrseq #(.POFF_CYC(POFF_CYC), .LDO_LEAD(LDO_LEAD)) u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wd2_exp   (wd2_exp),
        .ldo_gate  (ldo_gate),
        .buck_gate (buck_gate),
        .busy      (pc_busy)
    );

    sup_rstseq #(.RST_HOLD(RST_HOLD), .STAT_CLR(STAT_CLR)) u_rst (
        .clk         (clk),
        .rst_n       (rst_n),
        .mreset_n    (mreset_n),
        .rail_ok     (rail_ok),
        .pcycle_busy (pc_busy),
        .wd1_exp     (wd1_exp),
        .wd2_exp     (wd2_exp),
        .rst_act     (rst_act),
        .cause       (cause)
    );

    always_comb begin
        en_d      = en_q;
        en_d.ldo  = ldo_en_req  && ldo_gate  && !uv_lock;
        en_d.buck = buck_en_req && buck_gate && !uv_lock;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign sys_rst_n   = !rst_act;
    assign ldo_en      = en_q.ldo;
    assign buck_en     = en_q.buck;
    assign reset_cause = cause;

    AST_UV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        uv_lock |=> (!ldo_en && !buck_en)); // R8
    AST_WD1_KEEPS_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (wd1_exp && !wd2_exp && !pc_busy) |=> (ldo_gate && buck_gate)); // R2
    AST_WD_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_act |-> (!wd1_exp && !wd2_exp)); // R11

endmodule

// File: tb/wdog_supervisor_test.sv
module wdog_supervisor_test;
    localparam int WD1_CYC  = 60;
    localparam int WD2_CYC  = 150;
    localparam int RST_HOLD = 12;
    localparam int POFF_CYC = 30;
    localparam int LDO_LEAD = 5;
    localparam int STAT_CLR = 80;

    // {uv_lock, ldo_en_req, buck_en_req, exp ldo_en, exp buck_en}
    localparam logic [4:0] VEC [0:5] = '{
        5'b0_11_11, 5'b0_10_10, 5'b0_01_01, 5'b0_00_00, 5'b1_11_00, 5'b0_11_11
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wd1_kick = 1'b0, wd1_float = 1'b1, wd1_mode = 1'b0;
    logic mreset_n = 1'b1, rail_ok = 1'b1, uv_lock = 1'b0;
    logic ldo_en_req = 1'b1, buck_en_req = 1'b1;
    logic auto_kick = 1'b1, bg_kick = 1'b0, man_kick = 1'b0;
    logic wd2_kick;
    logic sys_rst_n, ldo_en, buck_en;
    logic [1:0] reset_cause;
    int n_chk = 0, n_fail = 0;
    logic done = 1'b0;

    assign wd2_kick = auto_kick ? bg_kick : man_kick;

    always #2.5 clk = ~clk;

    wdog_supervisor #(
        .WD1_CYC(WD1_CYC), .WD2_CYC(WD2_CYC), .RST_HOLD(RST_HOLD),
        .POFF_CYC(POFF_CYC), .LDO_LEAD(LDO_LEAD), .STAT_CLR(STAT_CLR)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wd1_kick(wd1_kick), .wd1_float(wd1_float),
        .wd1_mode(wd1_mode), .wd2_kick(wd2_kick), .mreset_n(mreset_n),
        .rail_ok(rail_ok), .uv_lock(uv_lock), .ldo_en_req(ldo_en_req),
        .buck_en_req(buck_en_req), .sys_rst_n(sys_rst_n), .ldo_en(ldo_en),
        .buck_en(buck_en), .reset_cause(reset_cause)
    );

    initial begin
        int c;
        c = 0;
        forever begin
            @(negedge clk);
            c = c + 1;
            if (c == 20) begin
                c = 0;
                bg_kick = ~bg_kick;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_release();
        int k;
        k = 0;
        while (!sys_rst_n && k < 5000) begin
            tick(1);
            k++;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R12 power-on state
        tick(3);
        chk("R12", "sys_rst_n in POR", sys_rst_n, 0);
        chk("R12", "ldo_en in POR", ldo_en, 0);
        chk("R9", "cause after POR", reset_cause, 0);
        rst_n = 1'b1;
        tick(RST_HOLD - 1);
        chk("R12", "still held", sys_rst_n, 0);
        tick(1);
        chk("R12", "released", sys_rst_n, 1);
        chk("R9", "cause none after POR", reset_cause, 0);

        // R8 enable gating table
        for (int i = 0; i < 6; i++) begin
            uv_lock     = VEC[i][4];
            ldo_en_req  = VEC[i][3];
            buck_en_req = VEC[i][2];
            tick(2);
            chk("R8", "ldo_en vector", ldo_en, int'(VEC[i][1]));
            chk("R8", "buck_en vector", buck_en, int'(VEC[i][0]));
            chk("R8", "reset unaffected", sys_rst_n, 1);
        end

        // R4 / R5 manual reset
        mreset_n = 1'b0;
        tick(1);
        chk("R4", "manual asserts", sys_rst_n, 0);
        chk("R4", "cause ext", reset_cause, 3);
        tick(3);
        mreset_n = 1'b1;
        tick(RST_HOLD - 1);
        chk("R5", "manual hold", sys_rst_n, 0);
        tick(1);
        chk("R5", "manual release", sys_rst_n, 1);

        // R6 rail low
        rail_ok = 1'b0;
        tick(1);
        chk("R6", "rail asserts", sys_rst_n, 0);
        tick(5);
        rail_ok = 1'b1;
        tick(RST_HOLD - 1);
        chk("R6", "rail hold", sys_rst_n, 0);
        tick(1);
        chk("R6", "rail release", sys_rst_n, 1);
        chk("R6", "cause ext", reset_cause, 3);

        // R1 / R2 first watchdog
        wd1_float = 1'b0;
        for (int i = 0; i < 4; i++) begin
            wd1_kick = ~wd1_kick;
            tick(WD1_CYC - 15);
            chk("R1", "kicked no reset", sys_rst_n, 1);
        end
        wd1_kick = ~wd1_kick;
        tick(WD1_CYC);
        chk("R2", "before wd1 expiry", sys_rst_n, 1);
        tick(1);
        chk("R2", "wd1 expiry resets", sys_rst_n, 0);
        chk("R2", "cause wd1", reset_cause, 1);
        wd1_float = 1'b1;
        tick(2);
        chk("R2", "ldo kept", ldo_en, 1);
        chk("R2", "buck kept", buck_en, 1);

        // R10 status clear
        wait_release();
        tick(STAT_CLR - 1);
        chk("R10", "cause kept", reset_cause, 1);
        tick(1);
        chk("R10", "cause cleared", reset_cause, 0);

        // R3 floating disable
        tick(WD1_CYC + 30);
        chk("R3", "floating low mode disabled", sys_rst_n, 1);
        wd1_mode = 1'b1;
        tick(WD1_CYC - 1);
        chk("R3", "mode high before expiry", sys_rst_n, 1);
        tick(1);
        chk("R3", "mode high expires", sys_rst_n, 0);
        chk("R3", "cause wd1", reset_cause, 1);
        wd1_mode = 1'b0;
        wd1_float = 1'b0;
        wait_release();

        // R11 reset restarts count
        tick(WD1_CYC / 2);
        mreset_n = 1'b0;
        tick(2);
        mreset_n = 1'b1;
        wait_release();
        tick(WD1_CYC - 1);
        chk("R11", "count restarted", sys_rst_n, 1);
        tick(1);
        chk("R11", "expiry after full period", sys_rst_n, 0);
        wd1_float = 1'b1;
        wait_release();

        // R7 second watchdog power cycle
        man_kick = ~bg_kick;
        auto_kick = 1'b0;
        tick(WD2_CYC);
        chk("R7", "before wd2 expiry", sys_rst_n, 1);
        tick(1);
        chk("R7", "wd2 asserts", sys_rst_n, 0);
        chk("R7", "cause wd2", reset_cause, 2);
        tick(1);
        chk("R7", "ldo off", ldo_en, 0);
        chk("R7", "buck off", buck_en, 0);
        mreset_n = 1'b0;
        tick(3);
        mreset_n = 1'b1;
        chk("R9", "ext keeps wd2 cause", reset_cause, 2);
        tick(POFF_CYC - 4);
        chk("R7", "ldo still off", ldo_en, 0);
        tick(1);
        chk("R7", "ldo back", ldo_en, 1);
        chk("R7", "buck waits", buck_en, 0);
        tick(LDO_LEAD - 1);
        chk("R7", "buck still off", buck_en, 0);
        tick(1);
        chk("R7", "buck back", buck_en, 1);
        chk("R7", "reset held", sys_rst_n, 0);
        tick(RST_HOLD - 2);
        chk("R7", "reset held end", sys_rst_n, 0);
        tick(1);
        chk("R7", "reset released", sys_rst_n, 1);
        auto_kick = 1'b1;
        tick(5);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule